// File: doc/BRIEF.md
# GF(2^4) Polynomial-Basis Multiplier with Selectable Modulus

This block multiplies two 4-bit elements of the finite field GF(2^4), held in polynomial basis, and returns their 4-bit product reduced modulo an irreducible polynomial of degree four. The multiply is carry-less: every addition is an XOR. The bit products a_j AND b_k are first grouped into seven partial-product sets by degree j+k. The four low sets land directly on the result bits. The three high sets are folded back onto the low bits according to the tail of the chosen modulus.

A one-bit select picks one of two moduli at run time. The select is captured with the operands whenever the input strobe is high. The product and its valid flag come out of a single register stage, one clock after the input that produced them. The block fits wherever a small field multiply is needed inside a coding or cipher datapath and the modulus must be switchable.

Top module: `gf4_field_mult`

## Requirements
- R1: Partial-product set s_i is the XOR over all j+k=i of in_a[j] AND in_b[k], for i from 0 to 6. No carries propagate anywhere in the product.
- R2: With in_poly_sel=0 the modulus is x^4+x^3+1. out_z equals the product of in_a and in_b reduced modulo that polynomial, with bit i of each bus being the coefficient of x^i.
- R3: With in_poly_sel=1 the modulus is x^4+x+1. out_z equals the product reduced modulo that polynomial.
- R4: When the degrees of the two operands sum to at most 3, no reduction occurs. out_z equals the plain carry-less product, for example 0x2 times 0x4 gives 0x8 under both moduli.
- R5: The high sets fold according to the modulus. With select 0, x^4, x^5 and x^6 become 0x9, 0xB and 0xF. With select 1 they become 0x3, 0x6 and 0xC.
- R6: A zero operand gives a zero product under either modulus.
- R7: An operand of 0x1 returns the other operand unchanged under either modulus.
- R8: The product is commutative: swapping in_a and in_b gives the same out_z.
- R9: out_valid is high exactly in the cycle after a cycle in which in_valid was high and rst was low.
- R10: While in_valid is low, out_z keeps its last value whatever in_a and in_b do.
- R11: A synchronous active-high rst clears out_z to 0 and out_valid to 0 on the next clock edge. Inputs presented during reset are ignored.
- R12: in_poly_sel is sampled only together with valid operands. Changing it while in_valid is low, or after the sampling edge, does not alter out_z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_a, in_b and in_poly_sel as a request |
| in_a | input | 4 | First field element, bit i is coefficient of x^i |
| in_b | input | 4 | Second field element |
| in_poly_sel | input | 1 | 0 selects x^4+x^3+1, 1 selects x^4+x+1 |
| out_valid | output | 1 | Registered strobe for out_z |
| out_z | output | 4 | Registered reduced product |

## Verification
All 256 operand pairs are applied under each modulus and compared with a bit-serial shift-and-conditional-XOR model. This separates a wrong folding group for any of the three high sets, and it also tells the two moduli apart. The full result tables are then compared with their transposes, which exposes an asymmetric partial-product term. Directed pairs of single powers of x isolate x^4, x^5 and x^6, and directed pairs whose degrees sum to at most 3 isolate the in-field path. Idle cycles with moving operands and select, and a reset in the middle of a run, show whether the register stage captures only on a strobe and clears on reset.

// File: rtl/gf4_mult_pkg.sv
package gf4_mult_pkg;
  localparam int FIELD_W = 4;
  localparam int PP_W    = 2 * FIELD_W - 1;
  localparam int NUM_POLY = 2;
  // tails P0(x) of the two moduli, bit i = coefficient of x^i
  localparam logic [FIELD_W-1:0] TAIL_SEL0 = 4'b1001; // x^4 + x^3 + 1
  localparam logic [FIELD_W-1:0] TAIL_SEL1 = 4'b0011; // x^4 + x + 1
  typedef logic [FIELD_W-1:0] gf_elem_t;
endpackage

// File: rtl/gf4_partial_products.sv
module gf4_partial_products #(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-2:0]   s
);
  localparam int PP_W = 2 * W - 1;

  for (genvar i = 0; i < PP_W; i++) begin : g_set
    localparam int LO = (i >= W) ? (i - W + 1) : 0;
    localparam int HI = (i < W) ? i : (W - 1);
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int j = LO; j <= HI; j++) begin
        acc = acc ^ (a[j] & b[i-j]);
      end
    end
    assign s[i] = acc;
  end
endmodule

// File: rtl/gf4_reduce.sv
module gf4_reduce #(
  parameter int           W     = 4,
  parameter logic [W-1:0] TAIL0 = 4'b1001,
  parameter logic [W-1:0] TAIL1 = 4'b0011
) (
  input  logic [2*W-2:0] s,
  input  logic           sel,
  output logic [W-1:0]   z
);
  localparam int PP_W = 2 * W - 1;

  logic [1:0][W-1:0] red;

  for (genvar p = 0; p < 2; p++) begin : g_poly
    localparam logic [W-1:0] TAIL = (p == 0) ? TAIL0 : TAIL1;
    logic [PP_W-1:0] t;
    always_comb begin
      t = s;
      // fold from the top set down so re-created high terms are folded again
      for (int k = PP_W - 1; k >= W; k--) begin
        if (t[k]) begin
          t[k] = 1'b0;
          t[k-W +: W] = t[k-W +: W] ^ TAIL;
        end
      end
    end
    assign red[p] = t[W-1:0];
  end

  assign z = red[sel];
endmodule

// File: rtl/gf4_field_mult.sv
module gf4_field_mult
  import gf4_mult_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [FIELD_W-1:0] in_a,
  input  logic [FIELD_W-1:0] in_b,
  input  logic               in_poly_sel,
  output logic               out_valid,
  output logic [FIELD_W-1:0] out_z
);
  logic [PP_W-1:0] pp_sets;
  gf_elem_t        prod_c;

  gf4_partial_products #(.W(FIELD_W)) i_pp (
    .a (in_a),
    .b (in_b),
    .s (pp_sets)
  );

  gf4_reduce #(.W(FIELD_W), .TAIL0(TAIL_SEL0), .TAIL1(TAIL_SEL1)) i_red (
    .s   (pp_sets),
    .sel (in_poly_sel),
    .z   (prod_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_z     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_z <= prod_c;
    end
  end
endmodule

// File: rtl/gf4_mult_checker.sv
module gf4_mult_checker
  import gf4_mult_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [FIELD_W-1:0] in_a,
  input logic [FIELD_W-1:0] in_b,
  input logic               in_poly_sel,
  input logic               out_valid,
  input logic [FIELD_W-1:0] out_z
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_z)); // R10

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_a) == 4'h0 || $past(in_b) == 4'h0))
      |-> (out_z == 4'h0)); // R6

  AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_a) == 4'h1) |-> (out_z == $past(in_b))); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_z == 4'h0)); // R11

  AST_X6_FOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_a) == 4'h8 && $past(in_b) == 4'h8)
      |-> (out_z == ($past(in_poly_sel) ? 4'hC : 4'hF))); // R5
endmodule

bind gf4_field_mult gf4_mult_checker i_chk (.*);

// File: tb/test_gf4_field_mult.sv
module test_gf4_field_mult;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_a = 4'h0;
  logic [3:0] in_b = 4'h0;
  logic       in_poly_sel = 1'b0;
  logic       out_valid;
  logic [3:0] out_z;

  int checks = 0;
  int errors = 0;
  logic [3:0] table_q [2][16][16];

  always #4 clk = ~clk; // 125 MHz

  gf4_field_mult i_gf4_field_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_poly_sel(in_poly_sel), .out_valid(out_valid), .out_z(out_z)
  );

  function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b, input logic sel);
    logic [4:0] r;
    logic [4:0] poly;
    poly = sel ? 5'b10011 : 5'b11001;
    r = '0;
    for (int i = 3; i >= 0; i--) begin
      r = r << 1;
      if (r[4]) r = r ^ poly;
      if (b[i]) r = r ^ {1'b0, a};
    end
    return r[3:0];
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic sel, output logic [3:0] z);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_poly_sel = sel;
    @(posedge clk); #1;
    z = out_z;
  endtask

  task automatic t_reset();
    in_valid = 1'b1; in_a = 4'h5; in_b = 4'h7;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset out_valid", {3'b0, out_valid}, 4'h0);
    check("R11 reset out_z", out_z, 4'h0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_exhaustive();
    logic [3:0] z;
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          apply(4'(a), 4'(b), 1'(s), z);
          table_q[s][a][b] = z;
          check(s == 0 ? "R1 R2 exhaustive" : "R1 R3 exhaustive", z, ref_mul(4'(a), 4'(b), 1'(s)));
        end
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = a + 1; b < 16; b++)
          check("R8 commutative", table_q[s][a][b], table_q[s][b][a]);
  endtask

  task automatic t_fold();
    logic [3:0] z;
    for (int s = 0; s < 2; s++) begin
      apply(4'h2, 4'h4, 1'(s), z); check("R4 x*x^2", z, 4'h8);
      apply(4'h3, 4'h3, 1'(s), z); check("R4 (x+1)^2", z, 4'h5);
    end
    apply(4'h2, 4'h8, 1'b0, z); check("R5 x^4 sel0", z, 4'h9);
    apply(4'h4, 4'h8, 1'b0, z); check("R5 x^5 sel0", z, 4'hB);
    apply(4'h8, 4'h8, 1'b0, z); check("R5 x^6 sel0", z, 4'hF);
    apply(4'h2, 4'h8, 1'b1, z); check("R5 x^4 sel1", z, 4'h3);
    apply(4'h4, 4'h8, 1'b1, z); check("R5 x^5 sel1", z, 4'h6);
    apply(4'h8, 4'h8, 1'b1, z); check("R5 x^6 sel1", z, 4'hC);
  endtask

  task automatic t_zero_one();
    logic [3:0] z;
    for (int s = 0; s < 2; s++) begin
      apply(4'h0, 4'hD, 1'(s), z); check("R6 zero a", z, 4'h0);
      apply(4'hE, 4'h0, 1'(s), z); check("R6 zero b", z, 4'h0);
      apply(4'h1, 4'hB, 1'(s), z); check("R7 one a", z, 4'hB);
      apply(4'h6, 4'h1, 1'(s), z); check("R7 one b", z, 4'h6);
    end
  endtask

  task automatic t_latency_hold();
    logic [3:0] exp;
    exp = ref_mul(4'h3, 4'h7, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_a = 4'h3; in_b = 4'h7;
    @(posedge clk); #1;
    check("R9 idle out_valid low", {3'b0, out_valid}, 4'h0);
    @(negedge clk); in_valid = 1'b1; in_poly_sel = 1'b0;
    @(posedge clk); #1;
    check("R9 out_valid one cycle later", {3'b0, out_valid}, 4'h1);
    check("R9 product after one cycle", out_z, exp);
    @(negedge clk); in_valid = 1'b0; in_a = 4'hF; in_b = 4'hF; in_poly_sel = 1'b1;
    @(posedge clk); #1;
    check("R9 out_valid drops", {3'b0, out_valid}, 4'h0);
    check("R10 hold idle", out_z, exp);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_a = 4'(i + 9); in_poly_sel = ~in_poly_sel;
      @(posedge clk); #1;
      check("R10 R12 hold under moving inputs", out_z, exp);
    end
    // select moves right after the sampling edge
    @(negedge clk); in_valid = 1'b1; in_a = 4'h4; in_b = 4'h8; in_poly_sel = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b0; in_poly_sel = 1'b1;
    @(posedge clk); #1;
    check("R12 select sampled with operands", out_z, 4'hB);
  endtask

  task automatic t_mid_reset();
    logic [3:0] z;
    apply(4'h9, 4'h9, 1'b1, z);
    check("R3 before reset", z, ref_mul(4'h9, 4'h9, 1'b1));
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R11 mid reset out_z", out_z, 4'h0);
    check("R11 mid reset out_valid", {3'b0, out_valid}, 4'h0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_exhaustive();
        t_fold();
        t_zero_one();
        t_latency_hold();
        t_mid_reset();
      end
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule